// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a relative conditional branch for a small processor whose bytes are five bits wide and whose code addresses are fifteen bits wide. Given the address of the branch opcode, the condition byte, the two distance bytes and the current zero (ZF) and carry (CF) flags, it decides whether the branch is taken. It then produces the next program counter: the branch target when taken, the address just past the four-byte branch otherwise.

The caller presents one branch per cycle with `in_valid` high. One clock later the result appears on the registered outputs together with `out_valid`. Fetching the branch bytes and producing the flags happen elsewhere. The outputs keep their last result until the next valid input arrives.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `out_valid`=0, `out_taken`=0 and `out_next_pc`=0.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low in the cycle after each cycle with `in_valid` low.
- R3: Let m be the 4-bit mask {ZF&CF, !ZF&CF, ZF&!CF, !ZF&!CF}, with bit 3 on the left. The branch is taken exactly when (condition bits [3:0] & m) is nonzero. Every one of the 16 codes follows this rule; for example code 6 is ZF xor CF, code 9 is its complement, code 3 is !CF and code 10 is ZF.
- R4: Condition code 0 is never taken and condition code 15 is always taken, whatever the flags are.
- R5: Bit 4 of the condition byte has no effect on `out_taken` or on `out_next_pc`.
- R6: When taken, `out_next_pc` = (op_addr + 4 + D) mod 2^15, where D is the sign-extended distance.
- R7: When not taken, `out_next_pc` = (op_addr + 4) mod 2^15, whatever the distance bytes are.
- R8: D is the 10-bit two's-complement value whose bits [9:5] come from `dist_hi` and whose bits [4:0] come from `dist_lo`. Its range is -512 to +511.
- R9: In a cycle after `in_valid` was low, `out_taken` and `out_next_pc` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Branch operands present this cycle |
| op_addr | input | 15 | Code address of the branch opcode byte |
| cond_byte | input | 5 | Condition byte; low four bits select the condition |
| dist_lo | input | 5 | Low byte of the signed distance |
| dist_hi | input | 5 | High byte of the signed distance |
| zf | input | 1 | Zero flag |
| cf | input | 1 | Carry flag |
| out_valid | output | 1 | Registered result is fresh this cycle |
| out_taken | output | 1 | Registered branch decision |
| out_next_pc | output | 15 | Registered next program counter |

## Verification
A wrong bit in the flag-combination mask, or a swapped flag, shows up as a wrong `out_taken` one cycle after the branch is presented. It is only visible for the one flag pairing that hits that bit, so the bench sweeps all sixteen codes against all four flag pairings. An error in the displacement sign extension or the wrap only shows up at the next PC for negative distances or for addresses near the top of the space, again one cycle later. A capture register that updates while idle shows up at the first idle cycle after a result.

// File: rtl/bcr_pkg.sv
// Package: shared sizes and the result record of the branch resolver.
// Assumes byte width 5, 15-bit code addresses and 4-byte branch instructions.
package bcr_pkg;
    parameter int ADDR_W   = 15;
    parameter int BYTE_W   = 5;
    parameter int INSN_LEN = 4;
    parameter int FLAG_N   = 2;

    localparam int COND_W = 2 ** FLAG_N;
    localparam int DIST_W = 2 * BYTE_W;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] next_pc;
    } bcr_result_t;
endpackage

// File: rtl/bcr_cond_eval.sv
// Module: bcr_cond_eval
// Decides a branch condition. Each code bit enables one combination of the
// two flags (a minterm), so the 16 codes cover every boolean function of
// ZF and CF. Assumes the code input is already trimmed to COND_W bits.
module bcr_cond_eval #(
    parameter int FLAG_N = 2,
    localparam int COND_W = 2 ** FLAG_N
) (
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_N-1:0] flags,
    output logic              taken
);
    logic [COND_W-1:0] minterm;

    // One decoder line per flag combination; index bit k matches flag k.
    for (genvar i = 0; i < COND_W; i++) begin : g_minterm
        localparam logic [FLAG_N-1:0] PATTERN = FLAG_N'(i);
        assign minterm[i] = (flags == PATTERN);
    end

    // Taken when the code enables the combination that is present now.
    always_comb taken = |(cond & minterm);
endmodule

// File: rtl/bcr_disp_ext.sv
// Module: bcr_disp_ext
// Joins the two distance bytes (high byte on top) into a signed value and
// sign-extends it to the address width. Assumes ADDR_W > 2*BYTE_W.
module bcr_disp_ext #(
    parameter int BYTE_W = 5,
    parameter int ADDR_W = 15,
    localparam int DIST_W = 2 * BYTE_W
) (
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    output logic [ADDR_W-1:0] disp
);
    logic [DIST_W-1:0] raw;

    // Little-endian byte order: the later byte is the upper half.
    always_comb raw = {hi, lo};

    // Replicate the sign bit into the upper address bits.
    always_comb disp = {{(ADDR_W-DIST_W){raw[DIST_W-1]}}, raw};
endmodule

// File: rtl/bcr_addr_calc.sv
// Module: bcr_addr_calc
// Computes the fall-through address and the branch target in parallel.
// Both sums wrap modulo 2^ADDR_W. Assumes INSN_LEN fits in ADDR_W bits.
module bcr_addr_calc #(
    parameter int ADDR_W   = 15,
    parameter int INSN_LEN = 4
) (
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] disp,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] target_pc
);
    localparam logic [ADDR_W-1:0] LEN = ADDR_W'(INSN_LEN);

    // Address of the first byte after the branch instruction.
    always_comb fall_pc = op_addr + LEN;

    // Distance counts from the end of the instruction.
    always_comb target_pc = fall_pc + disp;
endmodule

// File: rtl/branch_resolver.sv
// Module: branch_resolver (top)
// Resolves one relative conditional branch per cycle. The result is
// registered and is flagged by out_valid one cycle after in_valid.
// Assumes the caller supplies consistent flags in the same cycle. Only the
// low COND_W bits of the condition byte are used.
module branch_resolver
    import bcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [BYTE_W-1:0] cond_byte,
    input  logic [BYTE_W-1:0] dist_lo,
    input  logic [BYTE_W-1:0] dist_hi,
    input  logic              zf,
    input  logic              cf,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_pc
);
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] target_pc;
    logic              taken_c;
    bcr_result_t       res_c;
    bcr_result_t       res_q;
    logic              valid_q;
    logic [BYTE_W-COND_W-1:0] unused_cond_hi;

    // Upper condition bits carry no meaning.
    always_comb unused_cond_hi = cond_byte[BYTE_W-1:COND_W];

    bcr_cond_eval #(.FLAG_N(FLAG_N)) u_cond (
        .cond  (cond_byte[COND_W-1:0]),
        .flags ({cf, zf}),
        .taken (taken_c)
    );

    bcr_disp_ext #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_disp (
        .lo   (dist_lo),
        .hi   (dist_hi),
        .disp (disp)
    );

    bcr_addr_calc #(.ADDR_W(ADDR_W), .INSN_LEN(INSN_LEN)) u_addr (
        .op_addr   (op_addr),
        .disp      (disp),
        .fall_pc   (fall_pc),
        .target_pc (target_pc)
    );

    // Pick the next PC from the decision.
    always_comb begin
        res_c.taken   = taken_c;
        res_c.next_pc = taken_c ? target_pc : fall_pc;
    end

    // Valid flag follows the input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    // Capture a result only when a branch is presented; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res_c;
    end

    assign out_valid   = valid_q;
    assign out_taken   = res_q.taken;
    assign out_next_pc = res_q.next_pc;
endmodule

// File: rtl/branch_resolver_chk.sv
// Module: branch_resolver_chk
// Property checker for branch_resolver, attached by the bind below.
module branch_resolver_chk
    import bcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] op_addr,
    input logic [BYTE_W-1:0] cond_byte,
    input logic              out_valid,
    input logic              out_taken,
    input logic [ADDR_W-1:0] out_next_pc
);
    localparam logic [ADDR_W-1:0] LEN = ADDR_W'(INSN_LEN);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_taken && out_next_pc == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_never_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_byte[COND_W-1:0] == '0) |=> !out_taken);

    assert_always_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_byte[COND_W-1:0] == '1) |=> out_taken);

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_taken || out_next_pc == $past(op_addr) + LEN));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_taken) && $stable(out_next_pc)));
endmodule

bind branch_resolver branch_resolver_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_addr     (op_addr),
    .cond_byte   (cond_byte),
    .out_valid   (out_valid),
    .out_taken   (out_taken),
    .out_next_pc (out_next_pc)
);

// File: tb/branch_resolver_bench.sv
// Bench for branch_resolver: vector table, full condition sweep, directed tests.
module branch_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [14:0] op_addr = '0;
    logic [4:0]  cond_byte = '0;
    logic [4:0]  dist_lo = '0;
    logic [4:0]  dist_hi = '0;
    logic        zf = 1'b0;
    logic        cf = 1'b0;
    logic        out_valid;
    logic        out_taken;
    logic [14:0] out_next_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    branch_resolver u_branch_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_addr(op_addr),
        .cond_byte(cond_byte), .dist_lo(dist_lo), .dist_hi(dist_hi),
        .zf(zf), .cf(cf), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc)
    );

    // Vector: addr, cond, hi, lo, zf, cf | expected taken, expected next pc
    localparam int NV = 12;
    localparam logic [47:0] VECS [NV] = '{
        {15'h0010, 5'h0f, 5'h00, 5'h03, 1'b0, 1'b0, 1'b1, 15'h0017},
        {15'h0010, 5'h00, 5'h00, 5'h03, 1'b0, 1'b0, 1'b0, 15'h0014},
        {15'h0100, 5'h0a, 5'h1f, 5'h1e, 1'b1, 1'b0, 1'b1, 15'h0102},
        {15'h0100, 5'h0a, 5'h1f, 5'h1e, 1'b0, 1'b0, 1'b0, 15'h0104},
        {15'h7ffe, 5'h0f, 5'h00, 5'h00, 1'b0, 1'b1, 1'b1, 15'h0002},
        {15'h0002, 5'h0f, 5'h10, 5'h00, 1'b1, 1'b1, 1'b1, 15'h7e06},
        {15'h1234, 5'h1f, 5'h0f, 5'h1f, 1'b0, 1'b0, 1'b1, 15'h1437},
        {15'h1234, 5'h10, 5'h0f, 5'h1f, 1'b1, 1'b1, 1'b0, 15'h1238},
        {15'h0040, 5'h06, 5'h00, 5'h08, 1'b1, 1'b1, 1'b0, 15'h0044},
        {15'h0040, 5'h06, 5'h00, 5'h08, 1'b1, 1'b0, 1'b1, 15'h004c},
        {15'h0040, 5'h09, 5'h00, 5'h08, 1'b1, 1'b1, 1'b1, 15'h004c},
        {15'h7ffc, 5'h0c, 5'h00, 5'h01, 1'b0, 1'b1, 1'b1, 15'h0001}
    };

    // Reference decision written from the boolean form of each code.
    function automatic logic ref_taken(input logic [3:0] c, input logic z, input logic f);
        case (c)
            4'h0: return 1'b0;
            4'h1: return !z && !f;
            4'h2: return z && !f;
            4'h3: return !f;
            4'h4: return !z && f;
            4'h5: return !z;
            4'h6: return z ^ f;
            4'h7: return !z || !f;
            4'h8: return z && f;
            4'h9: return !(z ^ f);
            4'ha: return z;
            4'hb: return z || !f;
            4'hc: return f;
            4'hd: return !z || f;
            4'he: return z || f;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [14:0] ref_pc(input logic [14:0] a, input logic [4:0] h,
                                           input logic [4:0] l, input logic t);
        logic [14:0] d;
        d = {{5{h[4]}}, h, l};
        return t ? (a + 15'd4 + d) : (a + 15'd4);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one branch at a falling edge, then sample after the capture edge.
    task automatic apply(input logic [14:0] a, input logic [4:0] c, input logic [4:0] h,
                         input logic [4:0] l, input logic z, input logic f);
        op_addr = a; cond_byte = c; dist_hi = h; dist_lo = l; zf = z; cf = f;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [14:0] held_pc;
        logic        held_t;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 16'(out_valid), 16'd0);
        check("R1 taken", 16'(out_taken), 16'd0);
        check("R1 pc", 16'(out_next_pc), 16'd0);
        rst_n = 1'b1;

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VECS[i];
            apply(v[47:33], v[32:28], v[27:23], v[22:18], v[17], v[16]);
            check("R2 valid", 16'(out_valid), 16'd1);
            check("R3/R4/R5 taken", 16'(out_taken), 16'(v[15]));
            check("R6/R7/R8 pc", 16'(out_next_pc), 16'(v[14:0]));
        end

        // R3: every code against every flag pairing, back-to-back; R5 via bit 4
        for (int c = 0; c < 16; c++) begin
            for (int fl = 0; fl < 4; fl++) begin
                logic t;
                t = ref_taken(4'(c), fl[0], fl[1]);
                apply(15'h2000, {fl[0] ^ c[0], 4'(c)}, 5'h1f, 5'h10, fl[0], fl[1]);
                check("R3 taken", 16'(out_taken), 16'(t));
                check("R6/R7 pc", 16'(out_next_pc),
                      16'(ref_pc(15'h2000, 5'h1f, 5'h10, t)));
            end
        end

        // R7: not taken ignores a large distance
        apply(15'h7ffd, 5'h00, 5'h0f, 5'h1f, 1'b1, 1'b1);
        check("R7 pc", 16'(out_next_pc), 16'h0001);

        // R5: bit 4 flipped, same result
        apply(15'h0300, 5'h05, 5'h10, 5'h01, 1'b0, 1'b1);
        held_pc = out_next_pc; held_t = out_taken;
        apply(15'h0300, 5'h15, 5'h10, 5'h01, 1'b0, 1'b1);
        check("R5 taken", 16'(out_taken), 16'(held_t));
        check("R5 pc", 16'(out_next_pc), 16'(held_pc));
        check("R8 pc", 16'(out_next_pc), 16'(15'h0300 + 15'd4 - 15'd511));

        // R2 and R9: idle after a result, inputs change meanwhile
        op_addr = 15'h0555; cond_byte = 5'h00;
        go_idle();
        check("R2 idle valid", 16'(out_valid), 16'd0);
        check("R9 hold taken", 16'(out_taken), 16'(held_t));
        check("R9 hold pc", 16'(out_next_pc), 16'(held_pc));
        go_idle();
        check("R9 hold pc 2", 16'(out_next_pc), 16'(held_pc));

        // R1: reset during activity clears outputs
        in_valid = 1'b1; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 mid valid", 16'(out_valid), 16'd0);
        check("R1 mid pc", 16'(out_next_pc), 16'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule